// File: doc/BRIEF.md
# I2C Command Packet Front End

This block sits between an I2C slave byte engine and a command-driven coprocessor. The byte engine reports bus events: start, a received address byte, a received data byte and stop. The block watches these events and decides whether to acknowledge the device address. In a write packet it reads the first data byte as a function code. That code selects one of four actions: rewind the buffer pointer, enter sleep, enter idle, or append command bytes to the input buffer.

Command bytes go into an on-chip buffer that behaves like a FIFO. A command may arrive split across several packets. The first stored byte gives the total length of the command, and bytes past that length are discarded. Execution is launched only by the Stop condition that closes a packet in which the command became complete. While the command runs, the block refuses its own address, so a polling master reads the NACK as busy. The execution logic reads the buffer through a separate read port. It reports the end of execution with a one-cycle done pulse.

Top module: `i2c_cmd_frontend`

## Requirements
- R1: On an address byte that follows a start, `addr_ack` is high in that same cycle only when bits 7:1 of the byte equal `dev_addr`, the block is neither busy nor dormant, and the byte follows a start. A byte with a different address gives no ack.
- R2: After function code 0x03, each data byte is written to the next buffer location. Writing continues from the location where the previous 0x03 packet stopped, so a command may be split across packets. The bytes can be read back on `rd_data` at `rd_addr`.
- R3: The first stored command byte (location 0) is the command length, shown on `cmd_len`. Once `cmd_count` reaches that length (or reaches 1 when the length is 0), further data bytes are dropped and `cmd_count` stays unchanged.
- R4: `exec_start` is a single-cycle pulse, registered one cycle after a Stop that closes a 0x03 packet while the command is complete. Receiving the last command byte does not raise it.
- R5: A Stop that arrives before the command is complete does not raise `exec_start`. The stored bytes and `cmd_count` are kept, and later 0x03 packets append to them.
- R6: From the `exec_start` pulse until an `exec_done` pulse, `dev_busy` is high and the device address is not acknowledged. `exec_done` clears `dev_busy`, `cmd_count` and `cmd_len`.
- R7: Function code 0x00 clears `cmd_count`, `cmd_len` and `overflow`, so the next 0x03 packet writes from location 0.
- R8: Function code 0x01 raises `sleep_mode`, clears `cmd_count`, `overflow` and the busy state, and makes the block ignore all bus events (no ack) until a `wake` pulse, which lowers `sleep_mode`.
- R9: Function code 0x02 raises `idle_mode` and makes the block ignore all bus events until `wake`. It keeps the stored command bytes and `cmd_count`.
- R10: After a function code in 0x04..0xFF, the remaining data bytes of that packet are not stored, and `cmd_count` does not change.
- R11: A command byte that arrives when `cmd_count` is already at least DEPTH (default 128) is not written to the buffer. It sets the sticky flag `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Seven-bit device address to match |
| ev_start | input | 1 | Start condition seen (one-cycle pulse) |
| ev_addr | input | 1 | Address byte on `rx_byte` (one-cycle pulse) |
| ev_data | input | 1 | Data byte on `rx_byte` (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| rx_byte | input | 8 | Byte delivered with `ev_addr` or `ev_data` |
| wake | input | 1 | Wake event, leaves sleep or idle |
| exec_done | input | 1 | Execution finished (one-cycle pulse) |
| rd_addr | input | AW | Buffer read address for the execution logic |
| addr_ack | output | 1 | ACK decision for the current address byte |
| exec_start | output | 1 | One-cycle pulse that launches execution |
| dev_busy | output | 1 | Command is executing |
| sleep_mode | output | 1 | Dormant after a sleep request |
| idle_mode | output | 1 | Dormant after an idle request |
| overflow | output | 1 | Command bytes were dropped past the buffer end |
| cmd_len | output | 8 | Length byte of the current command |
| cmd_count | output | 8 | Command bytes accepted so far |
| rd_data | output | 8 | Buffer contents at `rd_addr` |

## Verification
Three command patterns are used. In the first, a command is sent in one packet followed by extra bytes. In the second, it is split across two packets with a Stop in between. In the third, the length byte exceeds the buffer. These separate the length cap from the Stop trigger and from the buffer-end drop. Each function code is sent in its own packet: rewind, sleep, idle and an invalid code. After each one the count, the read port and the acknowledge of a following address byte are examined. This shows which codes clear state, which keep it, and which only discard data. Address bytes are also sent while executing and while dormant, and with a wrong address, to cover every reason for a NACK.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;

   typedef enum logic [7:0] {
      FN_REWIND = 8'h00,
      FN_SLEEP  = 8'h01,
      FN_IDLE   = 8'h02,
      FN_APPEND = 8'h03
   } fn_code_e;

   typedef enum logic [2:0] {
      PH_OFF,
      PH_WAIT,
      PH_FUNC,
      PH_CMD,
      PH_DROP
   } phase_e;

   typedef enum logic [1:0] {
      MD_ACTIVE,
      MD_SLEEP,
      MD_IDLE
   } mode_e;

endpackage

// File: rtl/cmdfe_gate.sv
module cmdfe_gate (
   input  logic       ev_addr,
   input  logic       expecting,
   input  logic [7:0] addr_byte,
   input  logic [6:0] dev_addr,
   input  logic       blocked,
   output logic       ack,
   output logic       is_write
);
   logic match;

   assign match    = (addr_byte[7:1] == dev_addr);
   assign is_write = ~addr_byte[0];
   assign ack      = ev_addr & expecting & match & ~blocked;
endmodule

// File: rtl/cmdfe_fill.sv
module cmdfe_fill #(
   parameter int DEPTH = 128,
   parameter int CW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_evt,
   input  logic [7:0]    wr_byte,
   output logic          store_en,
   output logic [AW-1:0] store_addr,
   output logic          complete,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] len,
   output logic          ovf
);
   logic in_range;
   logic take;

   assign in_range   = (int'(cnt) < DEPTH);
   assign complete   = (cnt != '0) && (cnt >= len);
   assign take       = wr_evt & ~complete;
   assign store_en   = take & in_range;
   assign store_addr = cnt[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         len <= '0;
         ovf <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         len <= '0;
         ovf <= 1'b0;
      end else if (take) begin
         cnt <= cnt + 1'b1;
         if (cnt == '0) len <= CW'(wr_byte);
         if (!in_range) ovf <= 1'b1;
      end
   end

   assert_hold_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && !clr) |=> $stable(cnt));

   assert_ovf_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(wr_evt));
endmodule

// File: rtl/cmdfe_buf.sv
module cmdfe_buf #(
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] rows [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (we && waddr == AW'(i)) q <= wdata;
      end
      assign rows[i] = q;
   end

   assign rdata = rows[raddr];
endmodule

// File: rtl/i2c_cmd_frontend.sv
module i2c_cmd_frontend
   import cmdfe_pkg::*;
#(
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [6:0]    dev_addr,
   input  logic          ev_start,
   input  logic          ev_addr,
   input  logic          ev_data,
   input  logic          ev_stop,
   input  logic [7:0]    rx_byte,
   input  logic          wake,
   input  logic          exec_done,
   input  logic [AW-1:0] rd_addr,
   output logic          addr_ack,
   output logic          exec_start,
   output logic          dev_busy,
   output logic          sleep_mode,
   output logic          idle_mode,
   output logic          overflow,
   output logic [CW-1:0] cmd_len,
   output logic [CW-1:0] cmd_count,
   output logic [7:0]    rd_data
);
   if (DEPTH < 8 || DEPTH > 256 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two between 8 and 256");
   end

   phase_e phase_q;
   mode_e  mode_q;
   logic   run_q;
   logic   start_q;

   logic active, blocked, is_write, complete;
   logic func_evt, fn_rewind, fn_sleep, clr, wr_evt;
   logic          store_en;
   logic [AW-1:0] store_addr;

   assign active    = (mode_q == MD_ACTIVE);
   assign blocked   = run_q | ~active;
   assign func_evt  = active & ev_data & (phase_q == PH_FUNC);
   assign fn_rewind = func_evt & (rx_byte == FN_REWIND);
   assign fn_sleep  = func_evt & (rx_byte == FN_SLEEP);
   assign clr       = fn_rewind | fn_sleep | (active & exec_done & run_q);
   assign wr_evt    = active & ev_data & (phase_q == PH_CMD) & ~run_q;

   cmdfe_gate u_gate (
      .ev_addr   (ev_addr),
      .expecting (phase_q == PH_WAIT),
      .addr_byte (rx_byte),
      .dev_addr  (dev_addr),
      .blocked   (blocked),
      .ack       (addr_ack),
      .is_write  (is_write)
   );

   cmdfe_fill #(.DEPTH(DEPTH), .CW(CW)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .wr_evt     (wr_evt),
      .wr_byte    (rx_byte),
      .store_en   (store_en),
      .store_addr (store_addr),
      .complete   (complete),
      .cnt        (cmd_count),
      .len        (cmd_len),
      .ovf        (overflow)
   );

   cmdfe_buf #(.DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .we    (store_en),
      .waddr (store_addr),
      .wdata (rx_byte),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         mode_q  <= MD_ACTIVE;
         run_q   <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (!active) begin
            phase_q <= PH_OFF;
            if (wake) mode_q <= MD_ACTIVE;
         end else begin
            if (exec_done) run_q <= 1'b0;
            if (ev_start) begin
               phase_q <= PH_WAIT;
            end else if (ev_addr) begin
               phase_q <= (addr_ack && is_write) ? PH_FUNC : PH_OFF;
            end else if (func_evt) begin
               case (rx_byte)
                  FN_APPEND: phase_q <= PH_CMD;
                  FN_REWIND: phase_q <= PH_OFF;
                  FN_SLEEP: begin
                     phase_q <= PH_OFF;
                     mode_q  <= MD_SLEEP;
                     run_q   <= 1'b0;
                  end
                  FN_IDLE: begin
                     phase_q <= PH_OFF;
                     mode_q  <= MD_IDLE;
                  end
                  default: phase_q <= PH_DROP;
               endcase
            end else if (ev_stop) begin
               phase_q <= PH_OFF;
               if (phase_q == PH_CMD && complete && !run_q) begin
                  start_q <= 1'b1;
                  run_q   <= 1'b1;
               end
            end
         end
      end
   end

   assign exec_start = start_q;
   assign dev_busy   = run_q;
   assign sleep_mode = (mode_q == MD_SLEEP);
   assign idle_mode  = (mode_q == MD_IDLE);

   assert_start_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exec_start |-> $past(ev_stop));

   assert_nack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ack |-> !dev_busy);

   assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_busy && !exec_done && !ev_data) |=> dev_busy);

   assert_dormant_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_mode || idle_mode) |-> !addr_ack);

   assert_sleep_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_mode) |-> (cmd_count == '0));
endmodule

// File: tb/i2c_cmd_frontend_test.sv
module i2c_cmd_frontend_test;
   localparam int DEPTH = 128;
   localparam int AW = $clog2(DEPTH);
   localparam logic [6:0] ADDR = 7'h64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_start = 0, ev_addr = 0, ev_data = 0, ev_stop = 0;
   logic wake = 0, exec_done = 0;
   logic [7:0] rx_byte = '0;
   logic [AW-1:0] rd_addr = '0;
   logic addr_ack, exec_start, dev_busy, sleep_mode, idle_mode, overflow;
   logic [7:0] cmd_len, cmd_count, rd_data;

   int checks = 0;
   int fails = 0;

   always #5 clk = ~clk;

   i2c_cmd_frontend #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .dev_addr(ADDR),
      .ev_start(ev_start), .ev_addr(ev_addr), .ev_data(ev_data), .ev_stop(ev_stop),
      .rx_byte(rx_byte), .wake(wake), .exec_done(exec_done), .rd_addr(rd_addr),
      .addr_ack(addr_ack), .exec_start(exec_start), .dev_busy(dev_busy),
      .sleep_mode(sleep_mode), .idle_mode(idle_mode), .overflow(overflow),
      .cmd_len(cmd_len), .cmd_count(cmd_count), .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_start;
      @(negedge clk); ev_start = 1;
      @(negedge clk); ev_start = 0;
   endtask

   task automatic do_addr(input logic [7:0] b, output logic ack);
      @(negedge clk); ev_addr = 1; rx_byte = b;
      #1 ack = addr_ack;
      @(negedge clk); ev_addr = 0;
   endtask

   task automatic do_byte(input logic [7:0] b);
      @(negedge clk); ev_data = 1; rx_byte = b;
      @(negedge clk); ev_data = 0;
   endtask

   task automatic do_stop(output logic started);
      @(negedge clk); ev_stop = 1;
      @(negedge clk); ev_stop = 0;
      started = exec_start;
   endtask

   task automatic pulse_done;
      @(negedge clk); exec_done = 1;
      @(negedge clk); exec_done = 0;
   endtask

   task automatic pulse_wake;
      @(negedge clk); wake = 1;
      @(negedge clk); wake = 0;
   endtask

   task automatic read_at(input int a, output logic [7:0] v);
      rd_addr = AW'(a);
      #1 v = rd_data;
   endtask

   // Full write packet: start, address, function code, data, optional stop.
   task automatic pkt(input logic [7:0] fc, input logic [7:0] d[$], input bit stop,
                      output logic started);
      logic ack;
      started = 0;
      do_start;
      do_addr({ADDR, 1'b0}, ack);
      do_byte(fc);
      foreach (d[i]) do_byte(d[i]);
      if (stop) do_stop(started);
   endtask

   task automatic t_reset;
      chk("R1 reset ack", addr_ack, 0);
      chk("R4 reset start", exec_start, 0);
      chk("R6 reset busy", dev_busy, 0);
      chk("R8 reset sleep", sleep_mode, 0);
      chk("R9 reset idle", idle_mode, 0);
      chk("R3 reset count", cmd_count, 0);
      chk("R11 reset ovf", overflow, 0);
   endtask

   task automatic t_address;
      logic ack, s;
      do_start; do_addr({7'h23, 1'b0}, ack);
      chk("R1 wrong address nack", ack, 0);
      do_stop(s);
      do_start; do_addr({ADDR, 1'b0}, ack);
      chk("R1 own address ack", ack, 1);
      do_stop(s);
   endtask

   task automatic t_split;
      logic s, ack;
      logic [7:0] v;
      pkt(8'h03, '{8'h05, 8'h11, 8'h22}, 1, s);
      chk("R5 early stop no start", s, 0);
      chk("R5 partial count kept", cmd_count, 3);
      pkt(8'h03, '{8'h33, 8'h44}, 0, s);
      chk("R4 no start on last byte", exec_start, 0);
      chk("R3 length byte", cmd_len, 5);
      do_byte(8'h99);
      chk("R3 extra byte dropped", cmd_count, 5);
      do_stop(s);
      chk("R4 start on stop", s, 1);
      @(negedge clk);
      chk("R4 single cycle pulse", exec_start, 0);
      read_at(0, v); chk("R2 loc0", v, 8'h05);
      read_at(2, v); chk("R2 loc2", v, 8'h22);
      read_at(3, v); chk("R2 loc3 second packet", v, 8'h33);
      read_at(4, v); chk("R2 loc4 second packet", v, 8'h44);
      chk("R6 busy after start", dev_busy, 1);
      do_start; do_addr({ADDR, 1'b0}, ack);
      chk("R6 nack while busy", ack, 0);
      do_stop(s);
      chk("R6 still busy", dev_busy, 1);
      pulse_done;
      chk("R6 done clears busy", dev_busy, 0);
      chk("R6 done clears count", cmd_count, 0);
   endtask

   task automatic t_rewind;
      logic s;
      logic [7:0] v;
      pkt(8'h03, '{8'h04, 8'hA1}, 1, s);
      pkt(8'h00, '{}, 1, s);
      chk("R7 rewind clears count", cmd_count, 0);
      pkt(8'h03, '{8'h03, 8'hB1, 8'hB2}, 1, s);
      chk("R7 restart completes", s, 1);
      read_at(0, v); chk("R7 new length at loc0", v, 8'h03);
      read_at(1, v); chk("R7 loc1", v, 8'hB1);
      pulse_done;
   endtask

   task automatic t_invalid;
      logic s;
      pkt(8'h07, '{8'h02, 8'h55}, 1, s);
      chk("R10 invalid code no data", cmd_count, 0);
      chk("R10 invalid code no start", s, 0);
      pkt(8'hFF, '{8'h01}, 1, s);
      chk("R10 code FF no data", cmd_count, 0);
   endtask

   task automatic t_idle;
      logic s, ack;
      pkt(8'h03, '{8'h03, 8'hC1}, 1, s);
      pkt(8'h02, '{}, 1, s);
      chk("R9 idle mode", idle_mode, 1);
      chk("R9 count retained", cmd_count, 2);
      do_start; do_addr({ADDR, 1'b0}, ack);
      chk("R9 nack while idle", ack, 0);
      pulse_wake;
      chk("R9 wake leaves idle", idle_mode, 0);
      pkt(8'h03, '{8'hC2}, 1, s);
      chk("R9 command resumes after idle", s, 1);
      pulse_done;
   endtask

   task automatic t_sleep;
      logic s, ack;
      pkt(8'h03, '{8'h03, 8'hD1}, 1, s);
      pkt(8'h01, '{}, 1, s);
      chk("R8 sleep mode", sleep_mode, 1);
      chk("R8 sleep clears count", cmd_count, 0);
      do_start; do_addr({ADDR, 1'b0}, ack);
      chk("R8 nack while asleep", ack, 0);
      do_byte(8'h03); do_byte(8'h02);
      chk("R8 bytes ignored asleep", cmd_count, 0);
      pulse_wake;
      chk("R8 wake leaves sleep", sleep_mode, 0);
   endtask

   task automatic t_overflow;
      logic s, ack;
      logic [7:0] v;
      do_start; do_addr({ADDR, 1'b0}, ack);
      do_byte(8'h03);
      do_byte(8'd200);
      for (int k = 1; k < 140; k++) do_byte(8'(k));
      do_stop(s);
      chk("R11 count past depth", cmd_count, 140);
      chk("R11 overflow flag", overflow, 1);
      read_at(127, v); chk("R11 last location", v, 8'd127);
      read_at(0, v); chk("R11 loc0 not wrapped", v, 8'd200);
      pkt(8'h00, '{}, 1, s);
      chk("R7 rewind clears overflow", overflow, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_address;
      t_split;
      t_rewind;
      t_invalid;
      t_idle;
      t_sleep;
      t_overflow;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule